// File: doc/BRIEF.md
# Lockstep Column-Distributed Integer Matrix Multiplier

This block multiplies two square signed integer matrices, C = A × B. It holds N identical processing elements that run in lockstep under one sequencer. Each element owns a private storage slice. The slice of element k holds column k of A, of B and of C. Any one row of a matrix is therefore spread across all elements, and all of its entries can be reached in a single cycle.

Each output row i is built in N+1 parallel steps. The first step zeroes row i of C in every element at once. In inner step j, element j reads its stored a_ij and drives it onto a shared broadcast line. Every element k then performs one fused multiply-add, c_ik ← c_ik + a_ij × b_jk, using the b_jk in its own slice. A full product therefore takes N·(N+1) cycles, against N³ multiply-adds for a single serial unit.

A host loads A and B and reads all three matrices through a word-addressed port. Each access selects a matrix, a row and a column. A one-cycle start pulse launches the product, and a done flag reports completion.

Top module: `simd_mm_top`

## Requirements
- R1: After reset, busy and done are 0, and every element of A, B and C reads as 0.
- R2: After a run, element (i,j) of C equals the exact signed sum over k of a_ik × b_kj, with no wraparound for the default widths.
- R3: Host matrix select codes are 0 = A, 1 = B, 2 = C and 3 = none. Writes with code 0 or 1 store the low DW bits at (row, col), and reads of A or B return them sign-extended. Writes with code 2 or 3 change nothing, and reads with code 3 return 0.
- R4: Each output row is cleared before it is accumulated, so repeating a run on the same A and B gives the same C rather than a sum of runs.
- R5: A start pulse sampled while idle raises busy at that edge. Exactly N·(N+1) clock edges later, busy falls and done rises at the same edge.
- R6: Done stays high until the next accepted start, and that start clears done at its own edge.
- R7: Host writes presented while busy are ignored.
- R8: A start pulse presented while busy is ignored and does not change the completion cycle.
- R9: All-maximum operands (every entry 127) and all-minimum operands (every entry −128) produce the exact products N·127² and N·128².

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches a product when idle |
| busy | output | 1 | High while parallel steps are running |
| done | output | 1 | High from completion until the next accepted start |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Matrix select: 0 A, 1 B, 2 C, 3 none |
| host_row | input | IW | Row index of the host access |
| host_col | input | IW | Column index of the host access, which selects the processing element |
| host_wdata | input | DW | Signed write data |
| host_rdata | output | AW | Signed read data, combinational from the selected element |

## Verification
The bench builds the block with its default parameters: N = 4, 8-bit operands and 20-bit accumulators. At this size all 4 × 4 entries can be compared against a software triple loop within a few thousand cycles, and the 20-step completion window can be counted edge by edge. The 8-bit operands also bring the extreme values 127 and −128 within reach. With four terms per sum, these stress the accumulator near its worst case without overflowing it.

// File: rtl/simd_mm_pkg.sv
package simd_mm_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_NONE = 2'd3
  } mat_sel_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_MAC   = 2'd2
  } pe_op_e;

  function automatic int total_steps(input int n);
    return n * (n + 1);
  endfunction

endpackage

// File: rtl/simd_mm_pe.sv
module simd_mm_pe
  import simd_mm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 20,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pe_op_e               op,
  input  logic [IW-1:0]        step_row,
  input  logic [IW-1:0]        step_k,
  input  logic signed [DW-1:0] bcast_a,
  input  logic                 we_a,
  input  logic                 we_b,
  input  logic [IW-1:0]        host_row,
  input  logic signed [DW-1:0] host_wdata,
  output logic signed [DW-1:0] a_at_step,
  output logic signed [DW-1:0] rd_a,
  output logic signed [DW-1:0] rd_b,
  output logic signed [AW-1:0] rd_c
);

  localparam int PW = 2 * DW;

  logic signed [DW-1:0] a_mem [N];
  logic signed [DW-1:0] b_mem [N];
  logic signed [AW-1:0] c_mem [N];

  function automatic logic signed [AW-1:0] mac_step(
    input logic signed [AW-1:0] acc,
    input logic signed [DW-1:0] x,
    input logic signed [DW-1:0] y
  );
    logic signed [PW-1:0] prod;
    prod = x * y;
    return acc + AW'(prod);
  endfunction

  assign a_at_step = a_mem[step_row];
  assign rd_a      = a_mem[host_row];
  assign rd_b      = b_mem[host_row];
  assign rd_c      = c_mem[host_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) begin
        a_mem[r] <= '0;
        b_mem[r] <= '0;
        c_mem[r] <= '0;
      end
    end else begin
      if (we_a) a_mem[host_row] <= host_wdata;
      if (we_b) b_mem[host_row] <= host_wdata;
      case (op)
        OP_CLEAR: c_mem[step_row] <= '0;
        OP_MAC:   c_mem[step_row] <= mac_step(c_mem[step_row], bcast_a, b_mem[step_k]);
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/simd_mm_ctrl.sv
module simd_mm_ctrl
  import simd_mm_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output pe_op_e        op,
  output logic [IW-1:0] row,
  output logic [IW-1:0] k,
  output logic          last_step
);

  localparam int PW = $clog2(N + 1);

  logic          busy_q;
  logic          done_q;
  logic [IW-1:0] row_q;
  logic [PW-1:0] ph_q;
  logic [PW-1:0] k_wide;

  assign k_wide    = ph_q - PW'(1);
  assign k         = k_wide[IW-1:0];
  assign row       = row_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign last_step = busy_q && (row_q == IW'(N - 1)) && (ph_q == PW'(N));

  always_comb begin
    if (!busy_q)          op = OP_IDLE;
    else if (ph_q == '0)  op = OP_CLEAR;
    else                  op = OP_MAC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      row_q  <= '0;
      ph_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        row_q  <= '0;
        ph_q   <= '0;
      end
    end else if (last_step) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else if (ph_q == PW'(N)) begin
      ph_q  <= '0;
      row_q <= row_q + IW'(1);
    end else begin
      ph_q <= ph_q + PW'(1);
    end
  end

endmodule

// File: rtl/simd_mm_top.sv
module simd_mm_top
  import simd_mm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 20,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic                 host_we,
  input  logic [1:0]           host_sel,
  input  logic [IW-1:0]        host_row,
  input  logic [IW-1:0]        host_col,
  input  logic signed [DW-1:0] host_wdata,
  output logic signed [AW-1:0] host_rdata
);

  pe_op_e        op;
  logic [IW-1:0] step_row;
  logic [IW-1:0] step_k;
  logic          last_step;
  logic          step_fire;
  logic          clear_fire;
  logic          mac_fire;
  logic          wr_accept;
  mat_sel_e      sel;

  logic signed [DW-1:0] pe_a_step [N];
  logic signed [DW-1:0] pe_rd_a   [N];
  logic signed [DW-1:0] pe_rd_b   [N];
  logic signed [AW-1:0] pe_rd_c   [N];
  logic signed [DW-1:0] bcast_a;

  assign sel        = mat_sel_e'(host_sel);
  assign step_fire  = (op != OP_IDLE);
  assign clear_fire = (op == OP_CLEAR);
  assign mac_fire   = (op == OP_MAC);
  assign wr_accept  = host_we && !busy;
  assign bcast_a    = pe_a_step[step_k];

  simd_mm_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .op        (op),
    .row       (step_row),
    .k         (step_k),
    .last_step (last_step)
  );

  for (genvar g = 0; g < N; g++) begin : g_pe
    logic we_a;
    logic we_b;
    assign we_a = wr_accept && (sel == SEL_A) && (host_col == IW'(g));
    assign we_b = wr_accept && (sel == SEL_B) && (host_col == IW'(g));

    simd_mm_pe #(.N(N), .DW(DW), .AW(AW), .IW(IW)) u_pe (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .step_row   (step_row),
      .step_k     (step_k),
      .bcast_a    (bcast_a),
      .we_a       (we_a),
      .we_b       (we_b),
      .host_row   (host_row),
      .host_wdata (host_wdata),
      .a_at_step  (pe_a_step[g]),
      .rd_a       (pe_rd_a[g]),
      .rd_b       (pe_rd_b[g]),
      .rd_c       (pe_rd_c[g])
    );
  end

  always_comb begin
    case (sel)
      SEL_A:   host_rdata = AW'(pe_rd_a[host_col]);
      SEL_B:   host_rdata = AW'(pe_rd_b[host_col]);
      SEL_C:   host_rdata = pe_rd_c[host_col];
      default: host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/simd_mm_chk.sv
module simd_mm_chk
  import simd_mm_pkg::*;
#(
  parameter int N = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic step_fire,
  input logic clear_fire,
  input logic mac_fire,
  input logic last_step,
  input logic wr_accept
);

  int steps_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                steps_seen <= 0;
    else if (start && !busy)   steps_seen <= 0;
    else if (step_fire)        steps_seen <= steps_seen + 1;
  end

  // R5: completion after exactly N*(N+1) parallel steps
  a_r5_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> steps_seen == total_steps(N));

  // R5, R8: busy is held until the final step, whatever start does
  a_r8_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_step |=> busy);

  // R5: busy and done never overlap
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6: done holds until a start arrives
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R6: an accepted start clears done
  a_r6_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && busy);

  // R7: no host write is accepted while busy
  a_r7_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_accept);

  // R4: every run opens with a clear step, and steps are exclusive
  a_r4_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> clear_fire);

  a_r4_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clear_fire, mac_fire}));

endmodule

bind simd_mm_top simd_mm_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .step_fire  (step_fire),
  .clear_fire (clear_fire),
  .mac_fire   (mac_fire),
  .last_step  (last_step),
  .wr_accept  (wr_accept)
);

// File: tb/tb_simd_mm_top.sv
module tb_simd_mm_top;

  localparam int N      = 4;
  localparam int DW     = 8;
  localparam int AW     = 20;
  localparam int IW     = 2;
  localparam int TCLK   = 10;
  localparam int NSTEPS = N * (N + 1);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic                 busy;
  logic                 done;
  logic                 host_we = 1'b0;
  logic [1:0]           host_sel = 2'd3;
  logic [IW-1:0]        host_row = '0;
  logic [IW-1:0]        host_col = '0;
  logic signed [DW-1:0] host_wdata = '0;
  logic signed [AW-1:0] host_rdata;

  int checks = 0;
  int fails  = 0;
  int ma [N][N];
  int mb [N][N];
  logic [31:0] seed = 32'h1234_5678;

  always #(TCLK/2) clk = ~clk;

  simd_mm_top #(.N(N), .DW(DW), .AW(AW)) dut (
    .clk, .rst_n, .start, .busy, .done, .host_we, .host_sel,
    .host_row, .host_col, .host_wdata, .host_rdata
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hwrite(input int sel, input int r, input int c, input int v);
    @(negedge clk);
    host_we = 1'b1; host_sel = 2'(sel); host_row = IW'(r); host_col = IW'(c);
    host_wdata = DW'(v);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input int sel, input int r, input int c, output int v);
    @(negedge clk);
    host_sel = 2'(sel); host_row = IW'(r); host_col = IW'(c);
    #1;
    v = int'(host_rdata);
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:16]));
  endfunction

  task automatic load_mats();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        hwrite(0, r, c, ma[r][c]);
        hwrite(1, r, c, mb[r][c]);
      end
  endtask

  // Launch a run; optionally poke a write and a start while busy. Returns completion edge count.
  task automatic run(input bit poke, output int edges);
    int m;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m = 0;
    while (!done && m < 200) begin
      if (poke && m == 2) begin
        host_we = 1'b1; host_sel = 2'd0; host_row = '0; host_col = '0;
        host_wdata = DW'(ma[0][0] ^ 8'h55);
        start = 1'b1;
      end
      @(negedge clk);
      host_we = 1'b0;
      start = 1'b0;
      m++;
      if (m == NSTEPS - 1)
        check(busy && !done, "R5 busy before final edge", int'(busy), 1);
    end
    edges = m;
  endtask

  task automatic check_c(input string req);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int exp = 0;
        int got;
        for (int k = 0; k < N; k++) exp += ma[i][k] * mb[k][j];
        hread(2, i, j, got);
        check(got == exp, req, got, exp);
      end
  endtask

  task automatic t_reset();
    int v;
    check(!busy && !done, "R1 busy/done after reset", int'({busy, done}), 0);
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < N; i++) begin
        hread(s, i, N - 1 - i, v);
        check(v == 0, "R1 matrix zero after reset", v, 0);
      end
  endtask

  task automatic t_host_port();
    int v;
    hwrite(0, 1, 2, -77);
    hwrite(1, 3, 0, 100);
    hwrite(2, 2, 2, 55);
    hwrite(3, 0, 0, 11);
    hread(0, 1, 2, v);  check(v == -77, "R3 read back A", v, -77);
    hread(1, 3, 0, v);  check(v == 100, "R3 read back B", v, 100);
    hread(2, 2, 2, v);  check(v == 0,   "R3 write to C ignored", v, 0);
    hread(3, 1, 2, v);  check(v == 0,   "R3 select none reads 0", v, 0);
    hread(0, 0, 0, v);  check(v == 0,   "R3 select none write ignored", v, 0);
  endtask

  task automatic t_random(input int reps);
    int e;
    for (int t = 0; t < reps; t++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          ma[r][c] = rnd8();
          mb[r][c] = rnd8();
        end
      load_mats();
      run(1'b0, e);
      check(e == NSTEPS, "R5 completion edge count", e, NSTEPS);
      check_c("R2 random product");
    end
  endtask

  task automatic t_corners();
    int e;
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          ma[r][c] = (p == 0) ? 127 : -128;
          mb[r][c] = (p == 0) ? 127 : -128;
        end
      load_mats();
      run(1'b0, e);
      check(e == NSTEPS, "R9 completion edge count", e, NSTEPS);
      check_c("R9 extreme operands");
    end
  endtask

  task automatic t_rerun();
    int e;
    run(1'b0, e);
    check(e == NSTEPS, "R4 rerun edge count", e, NSTEPS);
    check_c("R4 rerun gives same C");
  endtask

  task automatic t_busy_pokes();
    int e;
    int v;
    run(1'b1, e);
    check(e == NSTEPS, "R8 start while busy ignored", e, NSTEPS);
    hread(0, 0, 0, v);
    check(v == ma[0][0], "R7 write while busy ignored", v, ma[0][0]);
    check_c("R7 product unaffected by busy write");
  endtask

  task automatic t_done_hold();
    repeat (10) @(negedge clk);
    check(done && !busy, "R6 done held while idle", int'(done), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && busy, "R6 start clears done", int'(done), 0);
    while (!done) @(negedge clk);
    check(done, "R6 done after second run", int'(done), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host_port();
    t_random(3);
    t_corners();
    t_rerun();
    t_busy_pokes();
    t_done_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule